// File: doc/BRIEF.md
# DDR Input Capture Register

This block converts a data bus that carries a new word on every clock edge into two single-rate words. Each clock period delivers one pair. The low word holds the sample taken first. The high word holds the sample taken second. Both words change together on the launch edge.

In the normal setting, the first sample is taken on the falling edge of `clk` and the second on the rising edge. A dedicated stage retimes the falling-edge sample to the rising edge, so the pair leaves at the same instant. A parameter swaps the roles of the two edges.

Several controls sit around the capture path:
- A clock enable freezes all stored state.
- An asynchronous input clears or presets the block. When no asynchronous mode is chosen, the same input loads a parameter-selected power-up level.
- A synchronous input clears or sets each storage element at that element's own edge.

Top module: `ddr_in_capture`

## Requirements
- R1: With `INVERT_CLK`=0, on each rising edge of `clk` with `ce` high and no synchronous action, `dout_hi` takes the value `din` had just before that rising edge.
- R2: With `INVERT_CLK`=0, the same rising edge loads `dout_lo` with the `din` value captured at the preceding falling edge. `dout_hi` and `dout_lo` therefore change at the same edge, and `dout_lo` holds the older sample.
- R3: With `INVERT_CLK`=1, the edges swap:
  - the first sample is taken on the rising edge;
  - the second sample is taken on the falling edge;
  - both outputs update on the falling edge, with `dout_hi` = the falling-edge sample and `dout_lo` = the preceding rising-edge sample.
- R4: While `ce` is low and no reset acts, no element captures, and both outputs keep their values.
- R5: `arst` high acts at once, without waiting for any clock edge:
  - with `ASYNC_MODE`=1 it forces both outputs and the first-sample register to all zeros;
  - with `ASYNC_MODE`=2 it forces them to all ones.
- R6: `srst` high acts only at each element's capturing edge and regardless of `ce`:
  - with `SYNC_MODE`=1 it loads zeros;
  - with `SYNC_MODE`=2 it loads ones;
  - with `SYNC_MODE`=0 it has no effect on the data path.
- R7: With `ASYNC_MODE`=0, `arst` acts as the power-up pulse and loads all elements with the level given by `POWER_UP_HIGH` (1 = all ones, 0 = all zeros).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock; both edges are used |
| ce | input | 1 | Clock enable, active high |
| arst | input | 1 | Asynchronous clear/preset, or power-up load, active high |
| srst | input | 1 | Synchronous clear/set, active high |
| din | input | WIDTH | Double-rate data from the pin |
| dout_hi | output | WIDTH | Second sample of the pair |
| dout_lo | output | WIDTH | First sample of the pair |

## Verification
The assertions assume three things about the inputs:
- `din`, `ce`, `srst` and `arst` never change exactly on a clock edge.
- `arst` is never pulsed between two edges while `ce` is low, which would break the hold property.
- An asynchronous pulse spans at least one rising edge of `clk`, so that the sampled level check sees it.

The stimulus meets all three. It moves every input two time units after an edge. It asserts `arst` only with `ce` high and holds it across a full period.

// File: rtl/ddr_in_capture.sv
module ddr_in_capture #(
  parameter int WIDTH         = 8,
  parameter bit INVERT_CLK    = 1'b0,
  parameter int ASYNC_MODE    = 1,
  parameter int SYNC_MODE     = 1,
  parameter bit POWER_UP_HIGH = 1'b0
) (
  input  logic             clk,
  input  logic             ce,
  input  logic             arst,
  input  logic             srst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout_hi,
  output logic [WIDTH-1:0] dout_lo
);
  localparam bit ARST_ONES = (ASYNC_MODE == 2) || ((ASYNC_MODE == 0) && POWER_UP_HIGH);
  localparam logic [WIDTH-1:0] ARST_VAL = ARST_ONES ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
  localparam logic [WIDTH-1:0] SYNC_VAL = (SYNC_MODE == 2) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  logic cap_clk;
  logic sync_hit;
  logic [WIDTH-1:0] first_q, hi_q, lo_q;

  assign cap_clk  = clk ^ INVERT_CLK;
  assign sync_hit = (SYNC_MODE != 0) && srst;

  always_ff @(negedge cap_clk or posedge arst)
    if (arst)          first_q <= ARST_VAL;
    else if (sync_hit) first_q <= SYNC_VAL;
    else if (ce)       first_q <= din;

  always_ff @(posedge cap_clk or posedge arst)
    if (arst) begin
      hi_q <= ARST_VAL;
      lo_q <= ARST_VAL;
    end else if (sync_hit) begin
      hi_q <= SYNC_VAL;
      lo_q <= SYNC_VAL;
    end else if (ce) begin
      hi_q <= din;
      lo_q <= first_q;
    end

  assign dout_hi = hi_q;
  assign dout_lo = lo_q;

  AST_HI_CAPTURE: assert property (@(posedge cap_clk) disable iff (arst)
    (ce && !sync_hit) |=> dout_hi == $past(din)); // R1
  AST_LO_RETIMED: assert property (@(posedge cap_clk) disable iff (arst)
    (ce && !sync_hit) |=> dout_lo == $past(first_q)); // R2
  AST_HOLD_WHEN_OFF: assert property (@(posedge cap_clk) disable iff (arst)
    (!ce && !sync_hit) |=> ($stable(dout_hi) && $stable(dout_lo))); // R4
  AST_ASYNC_LEVEL: assert property (@(posedge clk)
    arst |-> (dout_hi == ARST_VAL && dout_lo == ARST_VAL)); // R5
  AST_SYNC_LEVEL: assert property (@(posedge cap_clk) disable iff (arst)
    sync_hit |=> (dout_hi == SYNC_VAL && dout_lo == SYNC_VAL)); // R6
endmodule

// File: tb/sim_ddr_in_capture.sv
module sim_ddr_in_capture;
  localparam int CLK_P = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic ce, arst, srst;
  logic [W-1:0] din;
  logic [W-1:0] h0, l0, h1, l1, h2, l2;
  int n_run = 0, n_fail = 0;
  logic [W-1:0] prev_s;

  ddr_in_capture #(.WIDTH(W)) u0 (.clk(clk), .ce(ce), .arst(arst), .srst(srst),
    .din(din), .dout_hi(h0), .dout_lo(l0));
  ddr_in_capture #(.WIDTH(W), .INVERT_CLK(1'b1), .ASYNC_MODE(2), .SYNC_MODE(2)) u1 (
    .clk(clk), .ce(ce), .arst(arst), .srst(srst), .din(din), .dout_hi(h1), .dout_lo(l1));
  ddr_in_capture #(.WIDTH(W), .ASYNC_MODE(0), .SYNC_MODE(0), .POWER_UP_HIGH(1'b1)) u2 (
    .clk(clk), .ce(ce), .arst(arst), .srst(srst), .din(din), .dout_hi(h2), .dout_lo(l2));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] f, input logic [W-1:0] s, input bit check);
    @(posedge clk); #2 din = f;
    @(negedge clk); #1;
    if (check) begin
      chk("R3 u1 hi", h1, f);
      chk("R3 u1 lo", l1, prev_s);
    end
    #1 din = s;
    @(posedge clk); #1;
    if (check) begin
      chk("R1 u0 hi", h0, s);
      chk("R2 u0 lo", l0, f);
      chk("R1 u2 hi", h2, s);
      chk("R2 u2 lo", l2, f);
    end
    prev_s = s;
  endtask

  task automatic test_reset_state();
    repeat (3) @(posedge clk);
    #2;
    chk("R5 clear hi", h0, 8'h00);
    chk("R5 clear lo", l0, 8'h00);
    chk("R5 preset hi", h1, 8'hFF);
    chk("R5 preset lo", l1, 8'hFF);
    chk("R7 power-up hi", h2, 8'hFF);
    chk("R7 power-up lo", l2, 8'hFF);
    arst = 1'b0;
    send(8'h00, 8'h00, 1'b0);
  endtask

  task automatic test_patterns();
    send(8'h11, 8'h22, 1'b1);
    send(8'hA5, 8'h5A, 1'b1);
    send(8'hFF, 8'h00, 1'b1);
    send(8'h00, 8'hFF, 1'b1);
    send(8'h3C, 8'hC3, 1'b1);
    for (int i = 0; i < 6; i++)
      send(W'(i * 37 + 5), W'(i * 91 + 17), 1'b1);
  endtask

  task automatic test_hold();
    logic [W-1:0] s0h, s0l, s1h, s1l;
    @(posedge clk); #2 ce = 1'b0;
    s0h = h0; s0l = l0; s1h = h1; s1l = l1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #2 din = W'(i * 29 + 99);
      @(posedge clk); #1;
      chk("R4 u0 hi hold", h0, s0h);
      chk("R4 u0 lo hold", l0, s0l);
      chk("R4 u1 hi hold", h1, s1h);
      chk("R4 u1 lo hold", l1, s1l);
    end
    #1 ce = 1'b1;
    send(8'h44, 8'h55, 1'b0);
    send(8'h66, 8'h77, 1'b1);
  endtask

  task automatic test_sync();
    logic [W-1:0] s0h, s0l;
    @(posedge clk); #2 din = 8'h5A; srst = 1'b1;
    s0h = h0; s0l = l0;
    @(negedge clk); #1;
    chk("R6 u1 set hi", h1, 8'hFF);
    chk("R6 u1 set lo", l1, 8'hFF);
    chk("R6 u0 edge-only hi", h0, s0h);
    chk("R6 u0 edge-only lo", l0, s0l);
    @(posedge clk); #1;
    chk("R6 u0 clear hi", h0, 8'h00);
    chk("R6 u0 clear lo", l0, 8'h00);
    chk("R6 u2 ignored hi", h2, 8'h5A);
    chk("R6 u2 ignored lo", l2, 8'h5A);
    #1 srst = 1'b0;
    send(8'h12, 8'h34, 1'b0);
    send(8'h56, 8'h78, 1'b1);
  endtask

  task automatic test_async();
    send(8'h81, 8'h42, 1'b1);
    @(posedge clk); #2 arst = 1'b1;
    #1;
    chk("R5 async clear hi", h0, 8'h00);
    chk("R5 async clear lo", l0, 8'h00);
    chk("R5 async preset hi", h1, 8'hFF);
    chk("R5 async preset lo", l1, 8'hFF);
    chk("R7 power-up reload hi", h2, 8'hFF);
    chk("R7 power-up reload lo", l2, 8'hFF);
    @(posedge clk); #2 arst = 1'b0;
    send(8'h9A, 8'hBC, 1'b0);
    send(8'hDE, 8'hF0, 1'b1);
  endtask

  initial begin
    ce = 1'b1; srst = 1'b0; din = '0; arst = 1'b0; prev_s = '0;
    #1 arst = 1'b1;
    test_reset_state();
    test_patterns();
    test_hold();
    test_sync();
    test_async();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule